// File: doc/BRIEF.md
# Power-On Initialization Sequencer with Self-Test Fault Coding

After a hardware reset, this block brings the interrupt-unit state to a known starting point. It issues one clear strobe to the pending-interrupt and mask registers and zeroes the fault word that it owns. In the same cycle it pulses a reset to both interval timers and the trigger-go counter. From the next cycle the timers run and the start-up ROM enable is high. The power-up-good indicator stays low. While the block is busy, interrupts and DMA are held off.

It then runs the built-in test phases one at a time, in a fixed order. Each phase is launched with a one-cycle strobe that carries the phase number. The phase answers with a done pulse and a pass bit. At the first failing phase the block writes that phase's number into the fault word and skips the remaining phases. The indicator stays low, and initialization still completes. When every phase passes, the indicator goes high instead. In both cases the sequence ends with a one-cycle start-execution pulse that presents address zero.

Top module: `init_seq_top`

## Requirements
- R1: While reset is asserted, the outputs hold these values: busy=1, pwr_ok=0, surom_en=0, tmr_run=0, regs_clr=0, tmr_rst=0, bit_start=0, exec_go=0 and fault_word=0.
- R2: After reset is released, regs_clr and tmr_rst go high together for exactly one cycle, and only once per reset.
- R3: surom_en and tmr_run are low in the regs_clr cycle and high from the next cycle onward, until the next reset.
- R4: The phases are launched in order 1, 2, 3, 4, 5. Each launch is a one-cycle bit_start pulse with the phase number on bit_sel. The next phase is launched only after a bit_done with bit_pass=1.
- R5: A bit_done pulse that arrives while no phase is outstanding has no effect on fault_word, pwr_ok or exec_go. This includes a pulse after the sequence has finished.
- R6: When phase p reports bit_pass=0, fault_word[2:0] becomes p and all other bits stay zero. These are bits 13 to 15 of the fault word in most-significant-first numbering. No later phase is launched.
- R7: pwr_ok goes high only after all five phases pass. After any failure it stays low.
- R8: The cycle after the final bit_done (either the failing one or the fifth pass), exec_go is high for exactly one cycle with exec_addr equal to zero. It happens once per reset.
- R9: busy stays high from reset through the exec_go cycle and is low afterwards. Interrupts and DMA are held off while busy is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; the block releases it synchronously |
| bit_done | input | 1 | One-cycle completion pulse from the active test phase |
| bit_pass | input | 1 | Result that comes with bit_done (1 = pass) |
| busy | output | 1 | Initialization in progress; holds off interrupts and DMA |
| regs_clr | output | 1 | One-cycle clear strobe for the pending-interrupt and mask registers |
| tmr_rst | output | 1 | One-cycle reset for both timers and the trigger-go counter |
| tmr_run | output | 1 | Run enable for both timers and the trigger-go counter |
| surom_en | output | 1 | Start-up ROM enable |
| pwr_ok | output | 1 | Power-up-good indicator |
| bit_start | output | 1 | One-cycle launch strobe for a test phase |
| bit_sel | output | 3 | Number (1 to 5) of the phase being launched |
| fault_word | output | 16 | Fault register; phase code in [2:0] |
| exec_go | output | 1 | One-cycle start-execution pulse |
| exec_addr | output | 16 | Start address, zero when exec_go is high |

## Verification
A state register that skips or repeats a phase appears at once on bit_sel at the next bit_start, or as a wrong count of launches. A phase counter that is off by one shows up in fault_word in the cycle after the failing done pulse. A bad pass decision shows up in the same cycle, because pwr_ok is already wrong when exec_go fires. A sequencer that leaves its wait state, or never reaches it, shows up as a second exec_go, as busy staying high, or as fault_word changing after a stray done pulse. Every case is swept: no failure or failure at each of the five phases, each with several response delays.

// File: rtl/init_seq_pkg.sv
package init_seq_pkg;
  typedef enum logic [2:0] {
    ST_HOLD   = 3'd0,
    ST_CLR    = 3'd1,
    ST_LAUNCH = 3'd2,
    ST_WAIT   = 3'd3,
    ST_FIN    = 3'd4,
    ST_IDLE   = 3'd5
  } seq_state_e;
endpackage

// File: rtl/init_rst_sync.sv
module init_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign srst_n = sync_q[STAGES-1];
endmodule

// File: rtl/init_seq_ctrl.sv
module init_seq_ctrl
  import init_seq_pkg::*;
#(
  parameter int NUM_PHASES = 5,
  parameter int PH_W       = 3
) (
  input  logic            clk,
  input  logic            srst_n,
  input  logic            bit_done,
  input  logic            bit_pass,
  output logic            clr_ev,
  output logic            launch,
  output logic            fail_ev,
  output logic            pass_all_ev,
  output logic            go,
  output logic            active,
  output logic [PH_W-1:0] phase
);
  localparam logic [PH_W-1:0] LAST_PH  = PH_W'(NUM_PHASES);
  localparam logic [PH_W-1:0] FIRST_PH = PH_W'(1);

  seq_state_e      state_q, state_d;
  logic [PH_W-1:0] phase_q, phase_d;
  logic            phase_en;

  always_comb begin
    state_d     = state_q;
    phase_d     = phase_q;
    phase_en    = 1'b0;
    clr_ev      = 1'b0;
    launch      = 1'b0;
    fail_ev     = 1'b0;
    pass_all_ev = 1'b0;
    go          = 1'b0;
    case (state_q)
      ST_HOLD: state_d = ST_CLR;
      ST_CLR: begin
        clr_ev   = 1'b1;
        phase_d  = FIRST_PH;
        phase_en = 1'b1;
        state_d  = ST_LAUNCH;
      end
      ST_LAUNCH: begin
        launch  = 1'b1;
        state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (bit_done) begin
          if (!bit_pass) begin
            fail_ev = 1'b1;
            state_d = ST_FIN;
          end else if (phase_q == LAST_PH) begin
            pass_all_ev = 1'b1;
            state_d     = ST_FIN;
          end else begin
            phase_d  = phase_q + FIRST_PH;
            phase_en = 1'b1;
            state_d  = ST_LAUNCH;
          end
        end
      end
      ST_FIN: begin
        go      = 1'b1;
        state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) state_q <= ST_HOLD;
    else         state_q <= state_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       phase_q <= '0;
    else if (phase_en) phase_q <= phase_d;
  end

  assign active = (state_q != ST_IDLE);
  assign phase  = phase_q;
endmodule

// File: rtl/init_seq_regs.sv
module init_seq_regs #(
  parameter int PH_W     = 3,
  parameter int FT_W     = 16,
  parameter int CODE_LSB = 0
) (
  input  logic            clk,
  input  logic            srst_n,
  input  logic            clr_ev,
  input  logic            fail_ev,
  input  logic            pass_all_ev,
  input  logic [PH_W-1:0] phase,
  output logic [FT_W-1:0] fault_word,
  output logic            pwr_ok,
  output logic            surom_en,
  output logic            tmr_run
);
  logic [FT_W-1:0] fault_q, fault_d;
  logic            fault_en;
  logic            pwr_q, pwr_d, pwr_en;
  logic            rom_q, run_q;

  always_comb begin
    fault_d  = fault_q;
    fault_en = clr_ev | fail_ev;
    if (clr_ev) fault_d = '0;
    else if (fail_ev) fault_d[CODE_LSB +: PH_W] = phase;
    pwr_en = clr_ev | pass_all_ev;
    pwr_d  = pass_all_ev;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)       fault_q <= '0;
    else if (fault_en) fault_q <= fault_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n)     pwr_q <= 1'b0;
    else if (pwr_en) pwr_q <= pwr_d;
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      rom_q <= 1'b0;
      run_q <= 1'b0;
    end else if (clr_ev) begin
      rom_q <= 1'b1;
      run_q <= 1'b1;
    end
  end

  assign fault_word = fault_q;
  assign pwr_ok     = pwr_q;
  assign surom_en   = rom_q;
  assign tmr_run    = run_q;
endmodule

// File: rtl/init_seq_top.sv
module init_seq_top #(
  parameter int NUM_PHASES = 5,
  parameter int FT_W       = 16,
  parameter int CODE_LSB   = 0,
  parameter int ADDR_W     = 16,
  parameter int PH_W       = $clog2(NUM_PHASES + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bit_done,
  input  logic              bit_pass,
  output logic              busy,
  output logic              regs_clr,
  output logic              tmr_rst,
  output logic              tmr_run,
  output logic              surom_en,
  output logic              pwr_ok,
  output logic              bit_start,
  output logic [PH_W-1:0]   bit_sel,
  output logic [FT_W-1:0]   fault_word,
  output logic              exec_go,
  output logic [ADDR_W-1:0] exec_addr
);
  logic            srst_n;
  logic            clr_ev, launch, fail_ev, pass_all_ev, go, active;
  logic [PH_W-1:0] phase;

  init_rst_sync #(.STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  init_seq_ctrl #(.NUM_PHASES(NUM_PHASES), .PH_W(PH_W)) u_ctrl (
    .clk         (clk),
    .srst_n      (srst_n),
    .bit_done    (bit_done),
    .bit_pass    (bit_pass),
    .clr_ev      (clr_ev),
    .launch      (launch),
    .fail_ev     (fail_ev),
    .pass_all_ev (pass_all_ev),
    .go          (go),
    .active      (active),
    .phase       (phase)
  );

  init_seq_regs #(.PH_W(PH_W), .FT_W(FT_W), .CODE_LSB(CODE_LSB)) u_regs (
    .clk         (clk),
    .srst_n      (srst_n),
    .clr_ev      (clr_ev),
    .fail_ev     (fail_ev),
    .pass_all_ev (pass_all_ev),
    .phase       (phase),
    .fault_word  (fault_word),
    .pwr_ok      (pwr_ok),
    .surom_en    (surom_en),
    .tmr_run     (tmr_run)
  );

  assign busy      = active;
  assign regs_clr  = clr_ev;
  assign tmr_rst   = clr_ev;
  assign bit_start = launch;
  assign bit_sel   = launch ? phase : '0;
  assign exec_go   = go;
  assign exec_addr = '0;
endmodule

// File: rtl/init_seq_chk.sv
module init_seq_chk #(
  parameter int NUM_PHASES = 5,
  parameter int FT_W       = 16,
  parameter int CODE_LSB   = 0,
  parameter int ADDR_W     = 16,
  parameter int PH_W       = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              regs_clr,
  input logic              tmr_rst,
  input logic              tmr_run,
  input logic              surom_en,
  input logic              pwr_ok,
  input logic              bit_start,
  input logic [PH_W-1:0]   bit_sel,
  input logic [FT_W-1:0]   fault_word,
  input logic              exec_go,
  input logic [ADDR_W-1:0] exec_addr
);
  AST_CLR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    regs_clr |=> !regs_clr); // R2
  AST_TMR_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_rst |=> (tmr_run && surom_en)); // R3
  AST_ROM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    surom_en |=> surom_en); // R3
  AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |=> !bit_start); // R4
  AST_SEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_start |-> (bit_sel != '0 && bit_sel <= PH_W'(NUM_PHASES))); // R4
  AST_FAIL_NO_PWR: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_word != '0) |-> !pwr_ok); // R7
  AST_PWR_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pwr_ok) |-> exec_go); // R7
  AST_GO_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |=> !exec_go); // R8
  AST_GO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> (exec_addr == '0)); // R8
  AST_GO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    exec_go |-> busy ##1 !busy); // R9
  AST_NO_START_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !bit_start); // R9
endmodule

bind init_seq_top init_seq_chk #(
  .NUM_PHASES(NUM_PHASES), .FT_W(FT_W), .CODE_LSB(CODE_LSB),
  .ADDR_W(ADDR_W), .PH_W(PH_W)
) u_chk (.*);

// File: tb/init_seq_top_tb.sv
module init_seq_top_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bit_done, bit_pass;
  logic        busy, regs_clr, tmr_rst, tmr_run, surom_en, pwr_ok;
  logic        bit_start, exec_go;
  logic [2:0]  bit_sel;
  logic [15:0] fault_word, exec_addr;

  int nchk = 0;
  int nfail = 0;

  always #10 clk = ~clk;

  init_seq_top u_dut (
    .clk(clk), .rst_n(rst_n), .bit_done(bit_done), .bit_pass(bit_pass),
    .busy(busy), .regs_clr(regs_clr), .tmr_rst(tmr_rst), .tmr_run(tmr_run),
    .surom_en(surom_en), .pwr_ok(pwr_ok), .bit_start(bit_start),
    .bit_sel(bit_sel), .fault_word(fault_word), .exec_go(exec_go),
    .exec_addr(exec_addr)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic run_case(input int fail, input int lat);
    int starts, gos, clrs, exp_ph, wcnt, clr_at, end_cnt, cyc, exp_starts, extra_go;
    logic [15:0] fw_keep;
    logic        pw_keep;
    rst_n = 1'b0; bit_done = 1'b0; bit_pass = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(busy && !pwr_ok && !surom_en && !tmr_run, "R1 flags", {busy, pwr_ok, surom_en, tmr_run}, 8);
    check(!regs_clr && !tmr_rst && !bit_start && !exec_go, "R1 pulses",
          {regs_clr, tmr_rst, bit_start, exec_go}, 0);
    check(fault_word == 16'd0, "R1 fault_word", fault_word, 0);
    rst_n = 1'b1;
    starts = 0; gos = 0; clrs = 0; exp_ph = 1; wcnt = -1; clr_at = -1; end_cnt = -1; cyc = 0;
    while (cyc < 400 && end_cnt != 0) begin
      @(negedge clk);
      cyc++;
      bit_done = 1'b0; bit_pass = 1'b0;
      if (end_cnt > 0) end_cnt--;
      if (clr_at >= 0 && cyc == clr_at + 1)
        check(surom_en && tmr_run, "R3 rise", {surom_en, tmr_run}, 3);
      if (regs_clr) begin
        clrs++; clr_at = cyc;
        check(tmr_rst, "R2 tmr_rst with clear", tmr_rst, 1);
        check(!surom_en && !tmr_run, "R3 low in clear cycle", {surom_en, tmr_run}, 0);
      end
      if (wcnt == 0) begin
        bit_done = 1'b1;
        bit_pass = (exp_ph != fail);
        exp_ph++;
        wcnt = -1;
      end else if (wcnt > 0) begin
        wcnt--;
      end
      if (bit_start) begin
        starts++;
        check(int'(bit_sel) == exp_ph, "R4 phase order", bit_sel, exp_ph);
        wcnt = lat;
      end
      if (exec_go) begin
        gos++;
        check(exec_addr == 16'd0, "R8 start address", exec_addr, 0);
        check(busy, "R9 busy during go", busy, 1);
        check(pwr_ok == (fail == 0), "R7 pwr_ok at go", pwr_ok, fail == 0);
        check(int'(fault_word) == fail, "R6 fault code at go", fault_word, fail);
        end_cnt = 3;
      end
    end
    exp_starts = (fail == 0) ? 5 : fail;
    check(starts == exp_starts, "R4/R6 launch count", starts, exp_starts);
    check(gos == 1, "R8 go count", gos, 1);
    check(clrs == 1, "R2 clear count", clrs, 1);
    check(!busy, "R9 idle after go", busy, 0);
    check(surom_en && tmr_run, "R3 still high", {surom_en, tmr_run}, 3);
    check(int'(fault_word) == fail, "R6 final fault_word", fault_word, fail);
    check(pwr_ok == (fail == 0), "R7 final pwr_ok", pwr_ok, fail == 0);
    // R5 stray done pulses after finishing
    fw_keep = fault_word; pw_keep = pwr_ok; extra_go = 0;
    bit_done = 1'b1; bit_pass = (lat == 1);
    repeat (2) begin
      @(negedge clk);
      if (exec_go) extra_go++;
    end
    bit_done = 1'b0;
    repeat (2) begin
      @(negedge clk);
      if (exec_go) extra_go++;
    end
    check(fault_word == fw_keep, "R5 fault_word unchanged", fault_word, fw_keep);
    check(pwr_ok == pw_keep, "R5 pwr_ok unchanged", pwr_ok, pw_keep);
    check(extra_go == 0, "R5 no extra go", extra_go, 0);
  endtask

  initial begin
    for (int f = 0; f <= 5; f++) begin
      for (int l = 0; l <= 3; l++) run_case(f, l);
    end
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule